// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two parallel data buses, side A and side B, and carries words between them in either direction. Each side owns a storage register that captures that side's bus value when its load strobe is high at a rising edge of the block clock. One shared active-low enable and one direction input decide which side, if either, is driven. For each direction a select input chooses what gets driven: the live value on the opposite bus (transparent) or the word held in the opposite side's register (stored).

Each bus appears as a separate input word, output word and output-enable, so the block works without tri-state nets. The surrounding pad or bus logic drives a side only when that side's output-enable is high. Captures do not depend on enable or direction. A word can be stored while both sides are isolated and shown later in stored mode.

Top module: `dual_bus_xcvr`

## Requirements
- R1: While rst_n is low, both storage registers are cleared to zero. A stored-mode readout right after reset gives 0x00 on either side.
- R2: At a rising clk edge with ld_a high, the A register takes a_in. At a rising clk edge with ld_b high, the B register takes b_in.
- R3: Captures happen whatever the values of en_n, dir_to_b and both selects, including while both sides are isolated.
- R4: When en_n is 1, a_oe and b_oe are both 0.
- R5: When en_n is 0 and dir_to_b is 1, b_oe is 1 and a_oe is 0. With a2b_stored at 0, b_out equals a_in in the same cycle.
- R6: When en_n is 0, dir_to_b is 1 and a2b_stored is 1, b_out equals the A register.
- R7: When en_n is 0 and dir_to_b is 0, a_oe is 1 and b_oe is 0. b2a_stored at 0 gives a_out = b_in; b2a_stored at 1 gives a_out = the B register.
- R8: In stored mode, the cycle after a capture edge on the source register shows the newly captured word on the driven output.
- R9: b2a_stored has no effect while side B is driven, and a2b_stored has no effect while side A is driven.
- R10: A register whose load strobe is low at an edge keeps its word.
- R11: An output word whose output-enable is 0 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; captures on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of both registers |
| a_in | input | WIDTH | Word currently present on bus A |
| a_out | output | WIDTH | Word to drive onto bus A |
| a_oe | output | 1 | Drive enable for bus A |
| b_in | input | WIDTH | Word currently present on bus B |
| b_out | output | WIDTH | Word to drive onto bus B |
| b_oe | output | 1 | Drive enable for bus B |
| ld_a | input | 1 | Capture strobe for the A register |
| ld_b | input | 1 | Capture strobe for the B register |
| en_n | input | 1 | Active-low enable for both outputs |
| dir_to_b | input | 1 | 1: drive side B; 0: drive side A |
| a2b_stored | input | 1 | Side B source: 0 live A bus, 1 A register |
| b2a_stored | input | 1 | Side A source: 0 live B bus, 1 B register |

## Verification
The transparent-path properties compare an output with the opposite input in the same cycle. They assume the input words do not change between the point where the selects are set and the point where the output is sampled. The bench changes every input only on the falling edge, so each value holds for a full half period before the next rising edge. The stored-mode and hold properties assume the mode inputs stay put for two cycles in a row. They only fire when the antecedent shows that this is so, so the random stimulus is free to change the mode in every cycle.

// File: rtl/dbx_pkg.sv
package dbx_pkg;

    // Which side of the transceiver is driven this cycle
    typedef enum logic [1:0] {
        ROUTE_NONE = 2'b00,
        ROUTE_TO_A = 2'b01,
        ROUTE_TO_B = 2'b10
    } route_e;

    localparam int SIDE_A = 0;
    localparam int SIDE_B = 1;
    localparam int NUM_SIDES = 2;

    // Route that makes a given side the driven one
    function automatic route_e drive_route(input int side);
        return (side == SIDE_A) ? ROUTE_TO_A : ROUTE_TO_B;
    endfunction

endpackage

// File: rtl/dbx_hold_reg.sv
module dbx_hold_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q
);

    typedef struct packed {
        logic [WIDTH-1:0] word;
    } hold_t;

    hold_t st_d, st_q;

    // Capture is unconditional on the strobe: no gating by output control
    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.word = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.word;

endmodule

// File: rtl/dbx_route_ctl.sv
module dbx_route_ctl
    import dbx_pkg::*;
(
    input  logic   en_n,
    input  logic   dir_to_b,
    output route_e route
);

    always_comb begin
        if (en_n) begin
            route = ROUTE_NONE;
        end else if (dir_to_b) begin
            route = ROUTE_TO_B;
        end else begin
            route = ROUTE_TO_A;
        end
    end

endmodule

// File: rtl/dbx_side_mux.sv
module dbx_side_mux
    import dbx_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int SIDE  = SIDE_A
) (
    input  route_e           route,
    input  logic             use_stored,
    input  logic [WIDTH-1:0] live_word,
    input  logic [WIDTH-1:0] stored_word,
    output logic [WIDTH-1:0] out_word,
    output logic             out_en
);

    localparam route_e MY_ROUTE = drive_route(SIDE);

    always_comb begin
        out_en   = (route == MY_ROUTE);
        out_word = '0;
        if (out_en) begin
            out_word = use_stored ? stored_word : live_word;
        end
    end

endmodule

// File: rtl/dual_bus_xcvr.sv
module dual_bus_xcvr
    import dbx_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic             b_oe,
    input  logic             ld_a,
    input  logic             ld_b,
    input  logic             en_n,
    input  logic             dir_to_b,
    input  logic             a2b_stored,
    input  logic             b2a_stored
);

    route_e           route;
    logic [WIDTH-1:0] bus_in   [NUM_SIDES];
    logic [WIDTH-1:0] held     [NUM_SIDES];
    logic [WIDTH-1:0] bus_out  [NUM_SIDES];
    logic             bus_oe   [NUM_SIDES];
    logic             load     [NUM_SIDES];
    logic             sel_into [NUM_SIDES];

    assign bus_in[SIDE_A]   = a_in;
    assign bus_in[SIDE_B]   = b_in;
    assign load[SIDE_A]     = ld_a;
    assign load[SIDE_B]     = ld_b;
    // Select that governs what is driven onto each side
    assign sel_into[SIDE_A] = b2a_stored;
    assign sel_into[SIDE_B] = a2b_stored;

    dbx_route_ctl u_route (
        .en_n     (en_n),
        .dir_to_b (dir_to_b),
        .route    (route)
    );

    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
        localparam int OTHER = NUM_SIDES - 1 - s;

        dbx_hold_reg #(.WIDTH(WIDTH)) u_hold (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (load[s]),
            .din   (bus_in[s]),
            .q     (held[s])
        );

        dbx_side_mux #(.WIDTH(WIDTH), .SIDE(s)) u_mux (
            .route       (route),
            .use_stored  (sel_into[s]),
            .live_word   (bus_in[OTHER]),
            .stored_word (held[OTHER]),
            .out_word    (bus_out[s]),
            .out_en      (bus_oe[s])
        );
    end

    assign a_out = bus_out[SIDE_A];
    assign a_oe  = bus_oe[SIDE_A];
    assign b_out = bus_out[SIDE_B];
    assign b_oe  = bus_oe[SIDE_B];

endmodule

// File: rtl/dual_bus_xcvr_chk.sv
module dual_bus_xcvr_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] a_out,
    input logic             a_oe,
    input logic [WIDTH-1:0] b_in,
    input logic [WIDTH-1:0] b_out,
    input logic             b_oe,
    input logic             ld_a,
    input logic             ld_b,
    input logic             en_n,
    input logic             dir_to_b,
    input logic             a2b_stored,
    input logic             b2a_stored
);

    logic b_from_reg, a_from_reg;
    assign b_from_reg = !en_n && dir_to_b && a2b_stored;
    assign a_from_reg = !en_n && !dir_to_b && b2a_stored;

    // R4
    isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_n |-> (!a_oe && !b_oe));

    // R5
    one_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({a_oe, b_oe}));

    // R5
    live_to_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_n && dir_to_b && !a2b_stored) |-> (b_oe && b_out == a_in));

    // R7
    live_to_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_n && !dir_to_b && !b2a_stored) |-> (a_oe && a_out == b_in));

    // R8
    stored_b_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_a ##1 b_from_reg) |-> (b_out == $past(a_in)));

    // R8
    stored_a_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_b ##1 a_from_reg) |-> (a_out == $past(b_in)));

    // R10
    hold_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((!ld_a && b_from_reg) ##1 b_from_reg) |-> $stable(b_out));

    // R10
    hold_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((!ld_b && a_from_reg) ##1 a_from_reg) |-> $stable(a_out));

    // R11
    quiet_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !a_oe |-> (a_out == '0));

    // R11
    quiet_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !b_oe |-> (b_out == '0));

endmodule

bind dual_bus_xcvr dual_bus_xcvr_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/dual_bus_xcvr_tb.sv
module dual_bus_xcvr_tb;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] a_out, b_out;
    logic         a_oe, b_oe;
    logic         ld_a = 0, ld_b = 0, en_n = 1, dir_to_b = 0;
    logic         a2b_stored = 0, b2a_stored = 0;

    int n_checks = 0;
    int n_errors = 0;
    logic [W-1:0] ref_a = '0, ref_b = '0;
    bit done = 0;

    always #4 clk = ~clk;

    dual_bus_xcvr #(.WIDTH(W)) u_dut (.*);

    function automatic logic exp_a_oe();
        return !en_n && !dir_to_b;
    endfunction
    function automatic logic exp_b_oe();
        return !en_n && dir_to_b;
    endfunction
    function automatic logic [W-1:0] exp_a_out();
        if (!exp_a_oe()) return '0;
        return b2a_stored ? ref_b : b_in;
    endfunction
    function automatic logic [W-1:0] exp_b_out();
        if (!exp_b_oe()) return '0;
        return a2b_stored ? ref_a : a_in;
    endfunction
    function automatic string mode_tag();
        if (en_n) return "R4/R11";
        if (dir_to_b) return a2b_stored ? "R6/R9" : "R5/R9";
        return "R7/R9";
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check({tag, " a_oe"}, {7'd0, a_oe}, {7'd0, exp_a_oe()});
        check({tag, " b_oe"}, {7'd0, b_oe}, {7'd0, exp_b_oe()});
        check({tag, " a_out"}, a_out, exp_a_out());
        check({tag, " b_out"}, b_out, exp_b_out());
    endtask

    // Drive on falling edge, check before the rising edge, update model after it
    task automatic step(input logic [W-1:0] av, input logic [W-1:0] bv,
                        input logic la, input logic lb, input logic [3:0] ctl,
                        input string tag);
        @(negedge clk);
        a_in = av; b_in = bv; ld_a = la; ld_b = lb;
        {en_n, dir_to_b, a2b_stored, b2a_stored} = ctl;
        #1;
        check_all(tag);
        @(posedge clk);
        if (la) ref_a = av;
        if (lb) ref_b = bv;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset leaves zero in both registers, seen in stored mode
        a_in = 8'hA5; b_in = 8'h5A; ld_a = 1; ld_b = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        ld_a = 0; ld_b = 0; rst_n = 1;
        {en_n, dir_to_b, a2b_stored, b2a_stored} = 4'b0110;
        #1; check("R1 b_out after reset", b_out, 8'h00);
        {en_n, dir_to_b, a2b_stored, b2a_stored} = 4'b0001;
        #1; check("R1 a_out after reset", a_out, 8'h00);

        // R3/R2: capture while isolated, then read back in stored mode
        step(8'h3C, 8'hC3, 1, 1, 4'b1011, "R3 isolated capture");
        step(8'hFF, 8'h00, 0, 0, 4'b0110, "R3 A stored readout");
        check("R3 b_out shows isolated capture", b_out, 8'h3C);
        step(8'h11, 8'h22, 0, 0, 4'b0001, "R3 B stored readout");
        check("R3 a_out shows isolated capture", a_out, 8'hC3);

        // R8: capture while in stored mode, new word shows the next cycle
        step(8'h77, 8'h00, 1, 0, 4'b0110, "R8 capture cycle");
        step(8'h00, 8'h00, 0, 0, 4'b0110, "R8 after capture");
        check("R8 b_out new word", b_out, 8'h77);
        step(8'h00, 8'h99, 0, 1, 4'b0001, "R8 capture cycle B");
        step(8'h00, 8'h00, 0, 0, 4'b0001, "R8 after capture B");
        check("R8 a_out new word", a_out, 8'h99);

        // R10: no strobe, registers keep their words
        step(8'hEE, 8'hDD, 0, 0, 4'b1000, "R10 no load");
        step(8'h00, 8'h00, 0, 0, 4'b0110, "R10 A kept");
        check("R10 A register kept", b_out, 8'h77);

        // R4..R7, R9: walk all sixteen control combinations
        for (int c = 0; c < 16; c++) begin
            step(8'h5A ^ 8'(c), 8'hA5 ^ 8'(c * 3), 0, 0, 4'(c), mode_tag());
        end

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            logic [W-1:0] av, bv;
            logic [3:0] ctl;
            logic la, lb;
            av = 8'($urandom); bv = 8'($urandom);
            ctl = 4'($urandom); la = 1'($urandom); lb = 1'($urandom);
            step(av, bv, la, lb, ctl, mode_tag());
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule